// File: doc/BRIEF.md
# Output-Selectable Radix-4 Butterfly

This block evaluates one output of a four-point DFT over signed 8-bit complex samples. It takes four complex inputs and a 2-bit bin index. A small decoder turns the index into three control lines. These lines steer a fixed network of six adder-subtractors, so the block needs no multiplier. The selected bin, divided by four, is captured in an output register together with a one-cycle valid flag.

In a pipelined radix-4 FFT whose length is a power of four, the surrounding stage applies twiddle factors and sequences the data. It holds the four samples for four accepted strobes and steps the index from 0 to 3, which collects the complete set of four bins. A rotation by ±j is made by exchanging the real and imaginary operand paths and choosing the sign of each final adder.

Top module: `r4b_top`

## Requirements
- R1: While rst_ni is low, y_re_o and y_im_o read 0 and valid_o reads 0.
- R2: valid_o is 1 in the cycle after a rising clock edge that samples in_valid_i = 1, and 0 in the cycle after an edge that samples in_valid_i = 0.
- R3: When the edge samples in_valid_i = 0, y_re_o and y_im_o keep their previous values, whatever the data and index inputs are doing.
- R4: With sel_i = 0, the output is floor((x0 + x1 + x2 + x3) / 4), taken separately on the real and imaginary parts.
- R5: With sel_i = 1, the output is floor((x0 − j·x1 − x2 + j·x3) / 4), where −j·(a + jb) = b − ja.
- R6: With sel_i = 2, the output is floor((x0 − x1 + x2 − x3) / 4) on both parts.
- R7: With sel_i = 3, the output is floor((x0 + j·x1 − x2 − j·x3) / 4), where +j·(a + jb) = −b + ja.
- R8: All values are signed two's complement. The /4 scaling is an arithmetic right shift by 2 of a 10-bit exact sum, so it rounds toward minus infinity and never overflows. Four inputs of −128 give −128 on bin 0, and four inputs of +127 give +127 on bin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Strobe that captures a new result |
| sel_i | input | 2 | Output bin index, 0 to 3 |
| x0_re_i | input | 8 | Sample 0, real part |
| x0_im_i | input | 8 | Sample 0, imaginary part |
| x1_re_i | input | 8 | Sample 1, real part |
| x1_im_i | input | 8 | Sample 1, imaginary part |
| x2_re_i | input | 8 | Sample 2, real part |
| x2_im_i | input | 8 | Sample 2, imaginary part |
| x3_re_i | input | 8 | Sample 3, real part |
| x3_im_i | input | 8 | Sample 3, imaginary part |
| y_re_o | output | 8 | Selected bin / 4, real part |
| y_im_o | output | 8 | Selected bin / 4, imaginary part |
| valid_o | output | 1 | High for one cycle after each strobe |

## Verification
The assertions check three things on every clock edge. First, valid_o follows the strobe with a one-cycle delay. Second, the output register holds its value when no strobe arrives. Third, each of the four bins matches a direct signed sum written term by term from its DFT row. The bench must show the reset values and the floor rounding of negative sums, which the assertions do not cover. It must also show the saturated corners at −128 and +127, and that the index sweep returns all four bins from a single set of samples.

// File: rtl/r4b_pkg.sv
package r4b_pkg;
  typedef struct packed {
    logic pair_sub; // stage one: differences instead of sums
    logic swap;     // stage two: exchange re/im of the odd operand
    logic out_sub;  // stage two: real path subtracts
  } r4b_ctrl_t;
endpackage

// File: rtl/r4b_ctrl_dec.sv
module r4b_ctrl_dec
  import r4b_pkg::*;
(
  input  logic [1:0] sel_i,
  output r4b_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o.pair_sub = sel_i[0];
    ctrl_o.swap     = sel_i[0];
    ctrl_o.out_sub  = sel_i[1];
  end
endmodule

// File: rtl/r4b_addsub.sv
module r4b_addsub #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic                sub_i,
  output logic signed [W:0]   s_o
);
  logic signed [W:0] a_x, b_x;
  assign a_x = {a_i[W-1], a_i};
  assign b_x = {b_i[W-1], b_i};
  assign s_o = sub_i ? (a_x - b_x) : (a_x + b_x);
endmodule

// File: rtl/r4b_top.sv
module r4b_top
  import r4b_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] x0_re_i,
  input  logic [DATA_W-1:0] x0_im_i,
  input  logic [DATA_W-1:0] x1_re_i,
  input  logic [DATA_W-1:0] x1_im_i,
  input  logic [DATA_W-1:0] x2_re_i,
  input  logic [DATA_W-1:0] x2_im_i,
  input  logic [DATA_W-1:0] x3_re_i,
  input  logic [DATA_W-1:0] x3_im_i,
  output logic [DATA_W-1:0] y_re_o,
  output logic [DATA_W-1:0] y_im_o,
  output logic              valid_o
);
  localparam int P_W   = DATA_W + 1;
  localparam int SUM_W = DATA_W + 2;
  localparam int N_PAIR = 2;

  r4b_ctrl_t ctrl;
  logic      im_sub;

  r4b_ctrl_dec u_dec (.sel_i(sel_i), .ctrl_o(ctrl));

  // sign-control gate for the imaginary output adder
  assign im_sub = ctrl.out_sub ^ ctrl.swap;

  logic signed [DATA_W-1:0] lo_re [N_PAIR];
  logic signed [DATA_W-1:0] lo_im [N_PAIR];
  logic signed [DATA_W-1:0] hi_re [N_PAIR];
  logic signed [DATA_W-1:0] hi_im [N_PAIR];
  logic signed [P_W-1:0]    pr_re [N_PAIR];
  logic signed [P_W-1:0]    pr_im [N_PAIR];

  // pair 0: x0 with x2, pair 1: x1 with x3
  assign lo_re[0] = x0_re_i;
  assign lo_im[0] = x0_im_i;
  assign hi_re[0] = x2_re_i;
  assign hi_im[0] = x2_im_i;
  assign lo_re[1] = x1_re_i;
  assign lo_im[1] = x1_im_i;
  assign hi_re[1] = x3_re_i;
  assign hi_im[1] = x3_im_i;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    r4b_addsub #(.W(DATA_W)) u_re (
      .a_i(lo_re[p]), .b_i(hi_re[p]), .sub_i(ctrl.pair_sub), .s_o(pr_re[p])
    );
    r4b_addsub #(.W(DATA_W)) u_im (
      .a_i(lo_im[p]), .b_i(hi_im[p]), .sub_i(ctrl.pair_sub), .s_o(pr_im[p])
    );
  end

  logic signed [P_W-1:0]   op_re, op_im;
  logic signed [SUM_W-1:0] sum_re, sum_im;

  // swap realises the ±j rotation of the odd pair
  assign op_re = ctrl.swap ? pr_im[1] : pr_re[1];
  assign op_im = ctrl.swap ? pr_re[1] : pr_im[1];

  r4b_addsub #(.W(P_W)) u_out_re (
    .a_i(pr_re[0]), .b_i(op_re), .sub_i(ctrl.out_sub), .s_o(sum_re)
  );
  r4b_addsub #(.W(P_W)) u_out_im (
    .a_i(pr_im[0]), .b_i(op_im), .sub_i(im_sub), .s_o(sum_im)
  );

  logic unused_lsb;
  assign unused_lsb = ^{sum_re[1:0], sum_im[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_re_o  <= '0;
      y_im_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        y_re_o <= sum_re[SUM_W-1:2];
        y_im_o <= sum_im[SUM_W-1:2];
      end
    end
  end
endmodule

// File: rtl/r4b_checker.sv
module r4b_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] x0_re_i,
  input logic [DATA_W-1:0] x0_im_i,
  input logic [DATA_W-1:0] x1_re_i,
  input logic [DATA_W-1:0] x1_im_i,
  input logic [DATA_W-1:0] x2_re_i,
  input logic [DATA_W-1:0] x2_im_i,
  input logic [DATA_W-1:0] x3_re_i,
  input logic [DATA_W-1:0] x3_im_i,
  input logic [DATA_W-1:0] y_re_o,
  input logic [DATA_W-1:0] y_im_o,
  input logic              valid_o
);
  localparam int SUM_W = DATA_W + 2;

  logic signed [SUM_W-1:0] a0, b0, a1, b1, a2, b2, a3, b3;
  assign a0 = SUM_W'($signed(x0_re_i));
  assign b0 = SUM_W'($signed(x0_im_i));
  assign a1 = SUM_W'($signed(x1_re_i));
  assign b1 = SUM_W'($signed(x1_im_i));
  assign a2 = SUM_W'($signed(x2_re_i));
  assign b2 = SUM_W'($signed(x2_im_i));
  assign a3 = SUM_W'($signed(x3_re_i));
  assign b3 = SUM_W'($signed(x3_im_i));

  logic signed [SUM_W-1:0] k0_re, k0_im, k1_re, k1_im, k2_re, k2_im, k3_re, k3_im;
  assign k0_re = a0 + a1 + a2 + a3;
  assign k0_im = b0 + b1 + b2 + b3;
  assign k1_re = a0 + b1 - a2 - b3;
  assign k1_im = b0 - a1 - b2 + a3;
  assign k2_re = a0 - a1 + a2 - a3;
  assign k2_im = b0 - b1 + b2 - b3;
  assign k3_re = a0 - b1 - a2 + b3;
  assign k3_im = b0 + a1 - b2 - a3;

  p_valid_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> valid_o);
  p_valid_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !valid_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(y_re_o) && $stable(y_im_o)));
  p_bin0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_i == 2'd0) |=>
      (y_re_o == $past(k0_re[SUM_W-1:2]) && y_im_o == $past(k0_im[SUM_W-1:2])));
  p_bin1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_i == 2'd1) |=>
      (y_re_o == $past(k1_re[SUM_W-1:2]) && y_im_o == $past(k1_im[SUM_W-1:2])));
  p_bin2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_i == 2'd2) |=>
      (y_re_o == $past(k2_re[SUM_W-1:2]) && y_im_o == $past(k2_im[SUM_W-1:2])));
  p_bin3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && sel_i == 2'd3) |=>
      (y_re_o == $past(k3_re[SUM_W-1:2]) && y_im_o == $past(k3_im[SUM_W-1:2])));

  logic unused_chk;
  assign unused_chk = ^{k0_re[1:0], k0_im[1:0], k1_re[1:0], k1_im[1:0],
                        k2_re[1:0], k2_im[1:0], k3_re[1:0], k3_im[1:0]};
endmodule

bind r4b_top r4b_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .sel_i(sel_i),
  .x0_re_i(x0_re_i), .x0_im_i(x0_im_i), .x1_re_i(x1_re_i), .x1_im_i(x1_im_i),
  .x2_re_i(x2_re_i), .x2_im_i(x2_im_i), .x3_re_i(x3_re_i), .x3_im_i(x3_im_i),
  .y_re_o(y_re_o), .y_im_o(y_im_o), .valid_o(valid_o)
);

// File: tb/r4b_top_test.sv
module r4b_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic [7:0] xr [4];
  logic [7:0] xi [4];
  logic [7:0] y_re_o, y_im_o;
  logic       valid_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  r4b_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .sel_i(sel_i),
    .x0_re_i(xr[0]), .x0_im_i(xi[0]), .x1_re_i(xr[1]), .x1_im_i(xi[1]),
    .x2_re_i(xr[2]), .x2_im_i(xi[2]), .x3_re_i(xr[3]), .x3_im_i(xi[3]),
    .y_re_o(y_re_o), .y_im_o(y_im_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string bin_req(input int k);
    case (k)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // model: sum of x_n rotated by (-j)^(k*n), then floor divide by 4
  task automatic model(input int k, output int er, output int ei);
    int sr = 0, si = 0;
    for (int n = 0; n < 4; n++) begin
      int a = int'($signed(xr[n]));
      int b = int'($signed(xi[n]));
      case ((k * n) % 4)
        0: begin sr += a;  si += b;  end
        1: begin sr += b;  si -= a;  end
        2: begin sr -= a;  si -= b;  end
        default: begin sr -= b; si += a; end
      endcase
    end
    er = sr >>> 2;
    ei = si >>> 2;
  endtask

  task automatic run_bin(input int k);
    int er, ei;
    model(k, er, ei);
    @(negedge clk_i);
    sel_i = 2'(k);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R2", int'(valid_o), 1);
    chk(bin_req(k), int'($signed(y_re_o)), er);
    chk(bin_req(k), int'($signed(y_im_o)), ei);
  endtask

  task automatic sweep_bins();
    for (int k = 0; k < 4; k++) run_bin(k);
  endtask

  task automatic fill(input int vr, input int vi);
    for (int n = 0; n < 4; n++) begin
      xr[n] = 8'(vr);
      xi[n] = 8'(vi);
    end
  endtask

  initial begin
    fill(0, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", int'(y_re_o), 0);
    chk("R1", int'(y_im_o), 0);
    chk("R1", int'(valid_o), 0);
    rst_ni = 1'b1;

    // R8 extremes
    fill(-128, -128);
    run_bin(0);
    chk("R8", int'($signed(y_re_o)), -128);
    sweep_bins();
    fill(127, 127);
    run_bin(0);
    chk("R8", int'($signed(y_im_o)), 127);
    sweep_bins();
    fill(127, -128);
    xr[1] = 8'h80; xi[1] = 8'h7f; xr[3] = 8'h80; xi[3] = 8'h7f;
    sweep_bins();
    // R8 floor rounding of a negative sum: -1 / 4 -> -1
    fill(0, 0);
    xr[0] = 8'hff; xi[2] = 8'hfd;
    run_bin(0);
    chk("R8", int'($signed(y_re_o)), -1);
    chk("R8", int'($signed(y_im_o)), -1);
    // impulses on each input through every bin
    for (int n = 0; n < 4; n++) begin
      fill(0, 0);
      xr[n] = 8'd100; xi[n] = 8'hc4;
      sweep_bins();
    end
    // random sweep
    for (int t = 0; t < 300; t++) begin
      for (int n = 0; n < 4; n++) begin
        xr[n] = 8'($urandom);
        xi[n] = 8'($urandom);
      end
      sweep_bins();
      if (t % 10 == 0) begin
        // R3: inputs and index change without strobe, output must hold
        logic [7:0] hr, hi;
        hr = y_re_o; hi = y_im_o;
        @(negedge clk_i);
        sel_i = sel_i + 2'd1;
        for (int n = 0; n < 4; n++) begin
          xr[n] = ~xr[n];
          xi[n] = xi[n] + 8'd37;
        end
        @(negedge clk_i);
        chk("R3", int'(y_re_o), int'(hr));
        chk("R3", int'(y_im_o), int'(hi));
        chk("R2", int'(valid_o), 0);
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule